// File: doc/BRIEF.md
# Receiver Source Mode Controller

This block decides which clock a digital audio receiver runs from and whether the receiver is demodulating incoming data or sitting in analog-source mode. After reset the receiver runs from the PLL's VCO with the PLL and demodulator enabled. The block moves to the crystal clock only after a qualified no-signal condition. It also moves there when the host asks for analog-source mode. In either case a crystal clock must be reported present.

While the receiver is in analog-source mode, the block overrides the status outputs with their lock-loss values. The two serial data outputs carry bits supplied by the host. The sample-rate code reads as cleared. Host-written input codes keep their stored value. Leaving host-requested mode always goes back through signal qualification, so the receiver returns to the VCO only once the input has shown activity for the programmed number of cycles.

Top module: `rx_srcmode_ctrl`

## Requirements
- R1: After reset `mode` is 0 (VCO run), `clk_sel_xtal` is 0 and `pll_en` is 1.
- R2: From mode 0, when `no_signal` is sampled high on `qual_cycles` consecutive clock edges (a value of 0 counts as 1) and `xtal_ok` is high, `mode` becomes 1 (crystal, signal lost) on the last of those edges. A shorter run leaves `mode` at 0.
- R3: From mode 1, when `no_signal` is sampled low on `qual_cycles` consecutive edges, `mode` returns to 0 on the last of those edges. A shorter run leaves it at 1.
- R4: `host_analog_req` high at an edge sets `mode` to 2 (host analog) at that edge. This takes priority over signal qualification from any state, provided `xtal_ok` is high or the mode is already nonzero.
- R5: In mode 2, `host_analog_req` low at an edge moves `mode` to 1, and the qualification count for returning to mode 0 restarts from zero.
- R6: While `xtal_ok` is low, mode 0 is never left, whatever `no_signal` and `host_analog_req` do.
- R7: `clk_sel_xtal` is registered and equals, one edge later, whether `mode` was nonzero. `pll_en` is always its inverse.
- R8: With `mode` nonzero, `error_o` is 1, `empha_o`, `vflag_o` and `dataout_o` are 0, and `sub_o` equals parameter SUB_UNLOCK (default 1). With `mode` 0, these outputs equal their `dm_` inputs.
- R9: With `mode` nonzero, `dout1`/`dout2` equal `host_dout1`/`host_dout2`. With `mode` 0 they equal `dm_dout1`/`dm_dout2`.
- R10: `fs_code_o` reads 0 with `mode` nonzero and `dm_fs_code` otherwise. `in_code_o` loads `code_wdata` only at an edge with `code_wr` high and holds in every mode otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_analog_req | input | 1 | Host request for analog-source mode |
| no_signal | input | 1 | Detector: no activity on selected input |
| xtal_ok | input | 1 | Crystal clock present |
| qual_cycles | input | CNT_W | Consecutive edges needed to change signal state |
| code_wr | input | 1 | Host write strobe for input code |
| code_wdata | input | CODE_W | Host input code value |
| host_dout1 | input | 1 | Host data bit for output 1 |
| host_dout2 | input | 1 | Host data bit for output 2 |
| dm_dout1 | input | 1 | Demodulated data output 1 |
| dm_dout2 | input | 1 | Demodulated data output 2 |
| dm_error | input | 1 | Demodulator error flag |
| dm_sub | input | SUB_W | Demodulator sub-code |
| dm_empha | input | 1 | Demodulator emphasis flag |
| dm_vflag | input | 1 | Demodulator validity flag |
| dm_dataout | input | 1 | Demodulator data-out status |
| dm_fs_code | input | FS_W | Detected sample-rate code |
| mode | output | 2 | 0 VCO run, 1 crystal signal-lost, 2 host analog |
| clk_sel_xtal | output | 1 | Registered clock select, 1 = crystal |
| pll_en | output | 1 | PLL and demodulator enable |
| dout1 | output | 1 | Serial data output 1 |
| dout2 | output | 1 | Serial data output 2 |
| error_o | output | 1 | Error status |
| sub_o | output | SUB_W | Sub-code status |
| empha_o | output | 1 | Emphasis status |
| vflag_o | output | 1 | Validity status |
| dataout_o | output | 1 | Data-out status |
| fs_code_o | output | FS_W | Host-readable sample-rate code |
| in_code_o | output | CODE_W | Retained host input code |

## Verification
Several properties are checked on every cycle: the status overrides in any nonzero mode, host priority, staying on the VCO without a crystal, holding the input code without a write, the inverse relation of `pll_en` and `clk_sel_xtal`, and that entry to mode 1 follows a sampled no-signal. Only the bench's scenarios can show the exact edge on which qualification completes for each count. The same applies to the one-edge lag of the clock select, the restart of the count on leaving host mode, and the pass-through values in mode 0. The bench covers these by sweeping counts 1 to 4 against run lengths 1 to 5.

// File: rtl/rx_srcmode_ctrl.sv
module rx_srcmode_ctrl #(
  parameter int CNT_W      = 8,
  parameter int SUB_W      = 4,
  parameter int CODE_W     = 8,
  parameter int FS_W       = 4,
  parameter int SUB_UNLOCK = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_analog_req,
  input  logic              no_signal,
  input  logic              xtal_ok,
  input  logic [CNT_W-1:0]  qual_cycles,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic              host_dout1,
  input  logic              host_dout2,
  input  logic              dm_dout1,
  input  logic              dm_dout2,
  input  logic              dm_error,
  input  logic [SUB_W-1:0]  dm_sub,
  input  logic              dm_empha,
  input  logic              dm_vflag,
  input  logic              dm_dataout,
  input  logic [FS_W-1:0]   dm_fs_code,
  output logic [1:0]        mode,
  output logic              clk_sel_xtal,
  output logic              pll_en,
  output logic              dout1,
  output logic              dout2,
  output logic              error_o,
  output logic [SUB_W-1:0]  sub_o,
  output logic              empha_o,
  output logic              vflag_o,
  output logic              dataout_o,
  output logic [FS_W-1:0]   fs_code_o,
  output logic [CODE_W-1:0] in_code_o
);

  localparam logic [1:0] M_VCO  = 2'd0;
  localparam logic [1:0] M_XTAL = 2'd1;
  localparam logic [1:0] M_HOST = 2'd2;
  localparam logic [SUB_W-1:0] SUB_LOCKERR = SUB_W'(SUB_UNLOCK);

  logic [1:0]       st, st_nx;
  logic [CNT_W-1:0] cnt;

  wire              cond     = (st == M_VCO) ? no_signal : !no_signal;
  wire [CNT_W:0]    cnt_inc  = {1'b0, cnt} + 1'b1;
  wire              qual_hit = cond && (cnt_inc >= {1'b0, qual_cycles});
  wire              analog   = (st != M_VCO);

  always_comb begin
    st_nx = st;
    if (host_analog_req && (xtal_ok || st != M_VCO))
      st_nx = M_HOST;
    else begin
      case (st)
        M_VCO:   if (qual_hit && xtal_ok) st_nx = M_XTAL;
        M_XTAL:  if (qual_hit) st_nx = M_VCO;
        M_HOST:  st_nx = M_XTAL;
        default: st_nx = M_VCO;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= M_VCO;
      cnt          <= '0;
      clk_sel_xtal <= 1'b0;
      pll_en       <= 1'b1;
      in_code_o    <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st || !cond)
        cnt <= '0;
      else if (cnt != {CNT_W{1'b1}})
        cnt <= cnt + 1'b1;
      clk_sel_xtal <= analog;
      pll_en       <= !analog;
      if (code_wr)
        in_code_o <= code_wdata;
    end
  end

  assign mode      = st;
  assign dout1     = analog ? host_dout1 : dm_dout1;
  assign dout2     = analog ? host_dout2 : dm_dout2;
  assign error_o   = analog ? 1'b1 : dm_error;
  assign sub_o     = analog ? SUB_LOCKERR : dm_sub;
  assign empha_o   = analog ? 1'b0 : dm_empha;
  assign vflag_o   = analog ? 1'b0 : dm_vflag;
  assign dataout_o = analog ? 1'b0 : dm_dataout;
  assign fs_code_o = analog ? '0 : dm_fs_code;

  AST_LOCKERR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_VCO) |-> (error_o && !empha_o && !vflag_o && !dataout_o && sub_o == SUB_LOCKERR)); // R8
  AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_analog_req && xtal_ok) |=> (mode == M_HOST)); // R4
  AST_NO_XTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_VCO && !xtal_ok) |=> (mode == M_VCO)); // R6
  AST_ENTRY_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_VCO && !host_analog_req && !no_signal) |=> (mode == M_VCO)); // R2
  AST_CODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !code_wr |=> $stable(in_code_o)); // R10
  AST_PLL_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en == !clk_sel_xtal); // R7

endmodule

// File: tb/rx_srcmode_ctrl_tb.sv
module rx_srcmode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_analog_req = 1'b0, no_signal = 1'b0, xtal_ok = 1'b1;
  logic [7:0] qual_cycles = 8'd1;
  logic code_wr = 1'b0;
  logic [7:0] code_wdata = '0;
  logic host_dout1 = 1'b0, host_dout2 = 1'b1;
  logic dm_dout1 = 1'b1, dm_dout2 = 1'b0;
  logic dm_error = 1'b0, dm_empha = 1'b1, dm_vflag = 1'b1, dm_dataout = 1'b1;
  logic [3:0] dm_sub = 4'hA, dm_fs_code = 4'h5;
  logic [1:0] mode;
  logic clk_sel_xtal, pll_en, dout1, dout2, error_o, empha_o, vflag_o, dataout_o;
  logic [3:0] sub_o, fs_code_o;
  logic [7:0] in_code_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_srcmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .host_analog_req(host_analog_req), .no_signal(no_signal),
    .xtal_ok(xtal_ok), .qual_cycles(qual_cycles), .code_wr(code_wr), .code_wdata(code_wdata),
    .host_dout1(host_dout1), .host_dout2(host_dout2), .dm_dout1(dm_dout1), .dm_dout2(dm_dout2),
    .dm_error(dm_error), .dm_sub(dm_sub), .dm_empha(dm_empha), .dm_vflag(dm_vflag),
    .dm_dataout(dm_dataout), .dm_fs_code(dm_fs_code), .mode(mode), .clk_sel_xtal(clk_sel_xtal),
    .pll_en(pll_en), .dout1(dout1), .dout2(dout2), .error_o(error_o), .sub_o(sub_o),
    .empha_o(empha_o), .vflag_o(vflag_o), .dataout_o(dataout_o), .fs_code_o(fs_code_o),
    .in_code_o(in_code_o));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_analog_req = 1'b0; no_signal = 1'b0; xtal_ok = 1'b1; code_wr = 1'b0;
    step(2);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state and mode 0 pass-through
    chk("R1 mode", mode, 0);
    chk("R1 clk_sel", clk_sel_xtal, 0);
    chk("R1 pll_en", pll_en, 1);
    chk("R8 pass error/sub", {error_o, sub_o, empha_o, vflag_o, dataout_o}, {1'b0, 4'hA, 3'b111});
    chk("R9 pass dout", {dout1, dout2}, 2'b10);
    chk("R10 pass fs", fs_code_o, 5);

    // R2 / R7 entry sweep
    for (int q = 1; q <= 4; q++) begin
      for (int l = 1; l <= 5; l++) begin
        qual_cycles = 8'(q);
        do_reset();
        no_signal = 1'b1;
        step(l);
        chk("R2 entry mode", mode, (l >= q) ? 1 : 0);
        chk("R7 clk_sel lag", clk_sel_xtal, (l - 1 >= q) ? 1 : 0);
        chk("R7 pll_en", pll_en, (l - 1 >= q) ? 0 : 1);
      end
    end

    // R3 exit sweep
    for (int q = 1; q <= 4; q++) begin
      for (int l = 1; l <= 5; l++) begin
        qual_cycles = 8'(q);
        do_reset();
        no_signal = 1'b1;
        step(q);
        no_signal = 1'b0;
        step(l);
        chk("R3 exit mode", mode, (l >= q) ? 0 : 1);
      end
    end

    // R2 zero count acts as one
    qual_cycles = 8'd0;
    do_reset();
    no_signal = 1'b1;
    step(1);
    chk("R2 zero count", mode, 1);

    // R6 no crystal
    qual_cycles = 8'd3;
    do_reset();
    xtal_ok = 1'b0; no_signal = 1'b1;
    step(6);
    chk("R6 no xtal signal loss", mode, 0);
    host_analog_req = 1'b1;
    step(2);
    chk("R6 no xtal host", mode, 0);
    chk("R6 clk_sel", clk_sel_xtal, 0);

    // R4 host priority, R8/R9/R10 overrides
    do_reset();
    code_wdata = 8'h3C; code_wr = 1'b1;
    step(1);
    code_wr = 1'b0;
    chk("R10 code write", in_code_o, 8'h3C);
    host_analog_req = 1'b1;
    step(1);
    chk("R4 host enter", mode, 2);
    dm_error = 1'b0; dm_empha = 1'b1; dm_vflag = 1'b1; dm_dataout = 1'b1;
    code_wdata = 8'h99;
    step(1);
    chk("R8 override", {error_o, sub_o, empha_o, vflag_o, dataout_o}, {1'b1, 4'h1, 3'b000});
    chk("R9 host dout", {dout1, dout2}, 2'b01);
    host_dout1 = 1'b1; host_dout2 = 1'b0;
    step(1);
    chk("R9 host dout flip", {dout1, dout2}, 2'b10);
    chk("R10 fs cleared", fs_code_o, 0);
    chk("R10 code kept", in_code_o, 8'h3C);
    chk("R7 clk_sel in host", {clk_sel_xtal, pll_en}, 2'b10);

    // R5 release goes through qualification, count restarts
    no_signal = 1'b0;
    step(1);
    host_analog_req = 1'b0;
    step(1);
    chk("R5 release to xtal", mode, 1);
    step(2);
    chk("R5 still qualifying", mode, 1);
    step(1);
    chk("R5 back to vco", mode, 0);

    // R4 priority over qualification from mode 1
    do_reset();
    no_signal = 1'b1;
    step(3);
    chk("R2 before host", mode, 1);
    host_analog_req = 1'b1; no_signal = 1'b0;
    step(4);
    chk("R4 host over exit", mode, 2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule